// File: doc/BRIEF.md
# Retimed SHA-1 Compression Core

This block applies the SHA-1 compression function to one padded 512-bit message block. It starts from a 160-bit chaining value and runs one round per clock. A strobe loads the block and the chaining value. Eighty clocks later the core presents the new chaining value and pulses a completion flag for one cycle. Padding, and the sequencing of several blocks, belong to the surrounding logic. To chain blocks, that logic feeds the previous result back in as the next chaining value.

The round is retimed around a register placed in the middle of the round. The register holds four working words as plain copies. It also holds a fifth word, which already contains the sum of the shifted-out word, the schedule word and the round constant. A sixth word holds the evaluated nonlinear function. With this split, the combinational part after the register needs only two additions to form the new leading word, and the other words are plain wiring or rotation. While that part runs, the pre-computation for the following round proceeds in parallel. A two-way selector in front of the register picks either the incoming chaining words, at load, or the round outputs, during iteration.

Top module: `sha1_precomp_core`

## Requirements
- R1: After reset, `chain_out` is all zeros and `done` is low.
- R2: Block loading and output word order:
  - A block with `msg_blk[511:480]` as the first schedule word is loaded with `chain_in[159:128]` as the first chaining word.
  - The single padded block for the three bytes 61 62 63 with the standard initial value gives a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d on `chain_out`, first word in bits 159:128.
- R3: For any block and any chaining value, `chain_out` equals the SHA-1 compression result. Each of the five working words is added modulo 2^32 to its chaining word.
- R4: `done` is high for exactly one cycle. It rises on the 81st rising edge counted from the edge that samples an accepted `start`, which is edge 0, so it is first seen after edge 80.
- R5: A `start` that arrives while a block is in progress is ignored. The running block completes on schedule with its own result.
- R6: `chain_out` changes only in the cycle in which `done` is high. Between results it holds its value whatever the inputs do.
- R7: Rounds 0–19 use the choose function with 5A827999. Rounds 20–39 use parity with 6ED9EBA1. Rounds 40–59 use majority with 8F1BBCDC. Rounds 60–79 use parity with CA62C1D6.
- R8: Schedule words 16 to 79 are the left rotation by one of the XOR of the words 3, 8, 14 and 16 positions earlier. They are produced from a 16-word sliding window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe; accepted only when idle |
| msg_blk | input | 512 | Padded message block, first word in the top bits |
| chain_in | input | 160 | Chaining value, first word in the top bits |
| chain_out | output | 160 | Updated chaining value, held until the next result |
| done | output | 1 | One-cycle pulse when `chain_out` is updated |

## Verification
The rising edge that samples an accepted `start` counts as edge 0. The digest and the `done` pulse are both due exactly 80 rising edges later. The bench drives inputs and samples outputs on the falling edge. It counts edges from the load and checks that `done` is still low after edge 79 and high after edge 80. At that same point it compares `chain_out` against a behavioural model. It then checks that `done` has dropped one falling edge later. For the ignored-strobe and hold cases, the bench keeps counting from the original load. It confirms that the result still lands on edge 80 with the first block's digest, and that `chain_out` does not move while the inputs change without a strobe.

// File: rtl/sha1_pc_pkg.sv
package sha1_pc_pkg;

   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   function automatic word_t rotl(input word_t x, input int unsigned n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction

   // round class: 0 choose, 1 parity, 2 majority, 3 parity
   function automatic logic [1:0] round_class(input int unsigned t);
      if (t < 20)      return 2'd0;
      else if (t < 40) return 2'd1;
      else if (t < 60) return 2'd2;
      else             return 2'd3;
   endfunction

   function automatic word_t round_k(input int unsigned t);
      case (round_class(t))
         2'd0:    return 32'h5A827999;
         2'd1:    return 32'h6ED9EBA1;
         2'd2:    return 32'h8F1BBCDC;
         default: return 32'hCA62C1D6;
      endcase
   endfunction

   function automatic word_t round_f(input int unsigned t, input word_t b,
                                     input word_t c, input word_t d);
      case (round_class(t))
         2'd0:    return (b & c) | (~b & d);
         2'd2:    return (b & c) | (b & d) | (c & d);
         default: return b ^ c ^ d;
      endcase
   endfunction

endpackage

// File: rtl/sha1_pc_ctrl.sv
module sha1_pc_ctrl #(
   parameter int OPS   = 80,
   parameter int CNT_W = $clog2(OPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             load,
   output logic             adv,
   output logic             last,
   output logic             busy,
   output logic [CNT_W-1:0] op_idx,
   output logic [CNT_W-1:0] pre_idx
);
   localparam logic [CNT_W-1:0] LAST_OP = CNT_W'(OPS - 1);

   logic             busy_q;
   logic [CNT_W-1:0] op_q;

   assign busy    = busy_q;
   assign op_idx  = op_q;
   assign load    = start && !busy_q;
   assign adv     = busy_q && (op_q != LAST_OP);
   assign last    = busy_q && (op_q == LAST_OP);
   assign pre_idx = load ? '0 : op_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         op_q   <= '0;
      end else if (adv) begin
         op_q   <= op_q + 1'b1;
      end else if (last) begin
         busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sha1_pc_sched.sv
module sha1_pc_sched
   import sha1_pc_pkg::*;
#(
   parameter int WIN = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  adv,
   input  logic [WIN*WORD_W-1:0] msg_blk,
   output word_t                 w_now
);
   localparam int TAP_A = WIN - 3;
   localparam int TAP_B = WIN - 8;
   localparam int TAP_C = WIN - 14;

   word_t win_q [WIN];
   word_t src   [WIN];
   word_t fresh;

   genvar gi;
   generate
      for (gi = 0; gi < WIN; gi++) begin : g_src
         assign src[gi] = load ? msg_blk[(WIN-1-gi)*WORD_W +: WORD_W] : win_q[gi];
      end
   endgenerate

   assign w_now = src[0];
   assign fresh = rotl(src[TAP_A] ^ src[TAP_B] ^ src[TAP_C] ^ src[0], 1);

   generate
      for (gi = 0; gi < WIN; gi++) begin : g_win
         if (gi == WIN - 1) begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)            win_q[gi] <= '0;
               else if (load || adv) win_q[gi] <= fresh;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)            win_q[gi] <= '0;
               else if (load || adv) win_q[gi] <= src[gi+1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sha1_pc_prestage.sv
module sha1_pc_prestage
   import sha1_pc_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic [159:0]     chain_in,
   input  word_t            rnd_a,
   input  word_t            rnd_b,
   input  word_t            rnd_c,
   input  word_t            rnd_d,
   input  word_t            rnd_e,
   input  word_t            w_now,
   input  logic [CNT_W-1:0] pre_idx,
   output word_t            as_q,
   output word_t            bs_q,
   output word_t            cs_q,
   output word_t            ds_q,
   output word_t            es_q,
   output word_t            gs_q
);
   word_t sel_a, sel_b, sel_c, sel_d, sel_e;
   word_t pre_e, pre_g;

   // two-way selector: chaining words at load, round outputs otherwise
   always_comb begin
      if (load) begin
         sel_a = chain_in[159:128];
         sel_b = chain_in[127:96];
         sel_c = chain_in[95:64];
         sel_d = chain_in[63:32];
         sel_e = chain_in[31:0];
      end else begin
         sel_a = rnd_a;
         sel_b = rnd_b;
         sel_c = rnd_c;
         sel_d = rnd_d;
         sel_e = rnd_e;
      end
      pre_e = sel_e + w_now + round_k(int'(pre_idx));
      pre_g = round_f(int'(pre_idx), sel_b, sel_c, sel_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_q <= '0;
         bs_q <= '0;
         cs_q <= '0;
         ds_q <= '0;
         es_q <= '0;
         gs_q <= '0;
      end else if (load || adv) begin
         as_q <= sel_a;
         bs_q <= sel_b;
         cs_q <= sel_c;
         ds_q <= sel_d;
         es_q <= pre_e;
         gs_q <= pre_g;
      end
   end

endmodule

// File: rtl/sha1_pc_final.sv
module sha1_pc_final
   import sha1_pc_pkg::*;
(
   input  word_t as_q,
   input  word_t bs_q,
   input  word_t cs_q,
   input  word_t ds_q,
   input  word_t es_q,
   input  word_t gs_q,
   output word_t rnd_a,
   output word_t rnd_b,
   output word_t rnd_c,
   output word_t rnd_d,
   output word_t rnd_e
);
   // two adders only: rotated lead word plus the two pre-computed terms
   assign rnd_a = rotl(as_q, 5) + es_q + gs_q;
   assign rnd_b = as_q;
   assign rnd_c = rotl(bs_q, 30);
   assign rnd_d = cs_q;
   assign rnd_e = ds_q;

endmodule

// File: rtl/sha1_precomp_core.sv
module sha1_precomp_core
   import sha1_pc_pkg::*;
#(
   parameter int OPS   = 80,
   parameter int WIN   = 16,
   parameter int HW    = 5,
   localparam int CNT_W = $clog2(OPS),
   localparam int BLK_W = WIN * WORD_W,
   localparam int CHN_W = HW * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BLK_W-1:0] msg_blk,
   input  logic [CHN_W-1:0] chain_in,
   output logic [CHN_W-1:0] chain_out,
   output logic             done
);
   generate
      if (OPS != 80 || WIN != 16 || HW != 5) begin : g_bad_cfg
         $error("sha1_precomp_core: OPS, WIN and HW are fixed by the algorithm");
      end
   endgenerate

   logic             load_w, adv_w, last_w, busy_w;
   logic [CNT_W-1:0] op_w, pre_idx_w;
   word_t            w_now;
   word_t            as_q, bs_q, cs_q, ds_q, es_q, gs_q;
   word_t            rnd_a, rnd_b, rnd_c, rnd_d, rnd_e;
   word_t            fin   [HW];
   logic [CHN_W-1:0] hsave_q;
   logic [CHN_W-1:0] sum_w;

   sha1_pc_ctrl #(.OPS(OPS), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load_w), .adv(adv_w), .last(last_w), .busy(busy_w),
      .op_idx(op_w), .pre_idx(pre_idx_w)
   );

   sha1_pc_sched #(.WIN(WIN)) u_sched (
      .clk(clk), .rst_n(rst_n), .load(load_w), .adv(adv_w),
      .msg_blk(msg_blk), .w_now(w_now)
   );

   sha1_pc_prestage #(.CNT_W(CNT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .load(load_w), .adv(adv_w),
      .chain_in(chain_in),
      .rnd_a(rnd_a), .rnd_b(rnd_b), .rnd_c(rnd_c), .rnd_d(rnd_d), .rnd_e(rnd_e),
      .w_now(w_now), .pre_idx(pre_idx_w),
      .as_q(as_q), .bs_q(bs_q), .cs_q(cs_q), .ds_q(ds_q), .es_q(es_q), .gs_q(gs_q)
   );

   sha1_pc_final u_final (
      .as_q(as_q), .bs_q(bs_q), .cs_q(cs_q), .ds_q(ds_q), .es_q(es_q), .gs_q(gs_q),
      .rnd_a(rnd_a), .rnd_b(rnd_b), .rnd_c(rnd_c), .rnd_d(rnd_d), .rnd_e(rnd_e)
   );

   assign fin[0] = rnd_a;
   assign fin[1] = rnd_b;
   assign fin[2] = rnd_c;
   assign fin[3] = rnd_d;
   assign fin[4] = rnd_e;

   genvar gi;
   generate
      for (gi = 0; gi < HW; gi++) begin : g_fold
         assign sum_w[(HW-1-gi)*WORD_W +: WORD_W] =
            hsave_q[(HW-1-gi)*WORD_W +: WORD_W] + fin[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsave_q   <= '0;
         chain_out <= '0;
         done      <= 1'b0;
      end else begin
         done <= last_w;
         if (load_w) hsave_q   <= chain_in;
         if (last_w) chain_out <= sum_w;
      end
   end

endmodule

// File: rtl/sha1_pc_checker.sv
module sha1_pc_checker #(
   parameter int OPS   = 80,
   parameter int CNT_W = 7,
   parameter int CHN_W = 160
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             done,
   input logic [CHN_W-1:0] chain_out,
   input logic             busy,
   input logic [CNT_W-1:0] op_idx
);
   localparam int LAT_W = $clog2(OPS + 2) + 1;

   logic [LAT_W-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_q <= '0;
      else if (start && !busy) since_q <= LAT_W'(1);
      else if (busy)           since_q <= since_q + 1'b1;
   end

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_q == LAT_W'(OPS + 1)));

   assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chain_out) |-> done);

   assert_restart_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && op_idx < CNT_W'(OPS - 1)) |=>
         (busy && op_idx == $past(op_idx) + 1'b1));

endmodule

bind sha1_precomp_core sha1_pc_checker #(.OPS(OPS), .CNT_W(CNT_W), .CHN_W(CHN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done),
   .chain_out(chain_out), .busy(busy_w), .op_idx(op_w)
);

// File: tb/tb_sha1_precomp_core.sv
module tb_sha1_precomp_core;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [511:0] msg_blk = '0;
   logic [159:0] chain_in = '0;
   logic [159:0] chain_out;
   logic         done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sha1_precomp_core dut (
      .clk(clk), .rst_n(rst_n), .start(start), .msg_blk(msg_blk),
      .chain_in(chain_in), .chain_out(chain_out), .done(done)
   );

   localparam logic [159:0] IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                  32'h10325476, 32'hC3D2E1F0};
   localparam logic [511:0] ABC_BLK = {32'h61626380, {14{32'h0}}, 32'h00000018};
   localparam logic [159:0] ABC_DIG = {32'ha9993e36, 32'h4706816a, 32'hba3e2571,
                                       32'h7850c26c, 32'h9cd0d89d};

   localparam int NV = 3;
   localparam logic [511:0] V_MSG [NV] = '{
      ABC_BLK,
      {4{128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0}},
      {16{32'hffffffff}}
   };
   localparam logic [159:0] V_CHN [NV] = '{
      IV,
      160'h01234567_89abcdef_fedcba98_76543210_deadbeef,
      {5{32'hffffffff}}
   };

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   // behavioural reference of the compression function
   function automatic logic [159:0] ref_model(input logic [511:0] m, input logic [159:0] h);
      logic [31:0] w [80];
      logic [31:0] a, b, c, d, e, f, k, tmp;
      for (int t = 0; t < 16; t++) w[t] = m[511 - 32*t -: 32];
      for (int t = 16; t < 80; t++) w[t] = rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
      a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
      for (int t = 0; t < 80; t++) begin
         if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
         else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
         else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
         else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
         tmp = rl(a, 5) + f + e + k + w[t];
         e = d; d = c; c = rl(b, 30); b = a; a = tmp;
      end
      return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
   endfunction

   task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // load at a falling edge; edge 0 samples the strobe
   task automatic kick(input logic [511:0] m, input logic [159:0] h);
      msg_blk  = m;
      chain_in = h;
      start    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic run_vector(input int i, input logic [159:0] exp);
      kick(V_MSG[i], V_CHN[i]);
      for (int k = 1; k <= 80; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == 79) check("R4 done low before edge 80", {159'd0, done}, 160'd0);
      end
      check("R4 done at edge 80", {159'd0, done}, 160'd1);
      check((i == 0) ? "R2 abc digest" : "R3 R7 R8 digest", chain_out, exp);
      @(negedge clk);
      check("R4 done single cycle", {159'd0, done}, 160'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [159:0] held;
      logic [159:0] exp_a;
      repeat (3) @(negedge clk);
      check("R1 reset chain_out", chain_out, 160'd0);
      check("R1 reset done", {159'd0, done}, 160'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_vector(i, (i == 0) ? ABC_DIG : ref_model(V_MSG[i], V_CHN[i]));
         repeat (2) @(negedge clk);
      end

      // R5: strobe mid-block with different data is ignored
      exp_a = ref_model(V_MSG[1], IV);
      kick(V_MSG[1], IV);
      repeat (9) @(negedge clk);
      kick(V_MSG[2], V_CHN[2]);
      for (int k = 11; k <= 80; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      check("R5 done on original schedule", {159'd0, done}, 160'd1);
      check("R5 result of first block", chain_out, exp_a);

      // R6: inputs change without a strobe; result holds
      held     = chain_out;
      msg_blk  = ~msg_blk;
      chain_in = ~chain_in;
      repeat (20) @(negedge clk);
      check("R6 chain_out held", chain_out, held);
      check("R6 no spurious done", {159'd0, done}, 160'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule